// File: doc/BRIEF.md
# Hypervisor Interrupt-Control Register Access Decoder

This block judges every system-register access aimed at the hypervisor's interrupt-control register and reports what the core must do with it. The access is identified by its five encoding fields. The decision depends on the exception level the access comes from, whether the hypervisor level is active, the two nested-virtualization controls, and the system-register-interface enables of the hypervisor and monitor levels. Reads and writes use the same encoding and get the same decision, so a single decoder serves both directions.

The block gives one of five outcomes as a one-hot vector. The outcomes are: undefined instruction, trap to the hypervisor level, trap to the monitor level, redirect to a memory slot, and direct register access. A trap also carries its exception syndrome class. A redirect also carries the byte offset of the memory slot. All outputs are registered, so a decision appears one clock after the access is presented. The block does not carry out traps, does not access memory and does not hold the register's contents.

Top module: `sysreg_trap_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs are zero after that edge.
- R2: `acc_hit` rises one cycle after `req_valid` is high with op0=2'b11, op1=3'b100, CRn=4'b1100, CRm=4'b1011 and op2=3'b000. For any other encoding, or when `req_valid` is low, all outputs are zero one cycle later.
- R3: An access from level 0 gives outcome bit 0 (undefined), whatever the other controls are.
- R4: At level 1, with `el2_on`, `nest_en` and `nest_mem` all set, the outcome is bit 3 (redirect) and `acc_offset` is 0x4C0.
- R5: At level 1, with `el2_on` and `nest_en` set but `nest_mem` clear, the outcome is bit 1 (trap to hypervisor) and `acc_class` is 0x18.
- R6: At level 1, when `el2_on` is clear or `nest_en` is clear, the outcome is bit 0 (undefined). This holds whatever `nest_mem` is.
- R7: At level 2, a clear `sre_hyp` gives bit 1 (trap to hypervisor) with class 0x18. A set `sre_hyp` gives bit 4 (direct access). `sre_mon` has no effect here.
- R8: At level 3, a clear `sre_mon` gives bit 2 (trap to monitor) with class 0x18. A set `sre_mon` gives bit 4 (direct access). `sre_hyp` has no effect here.
- R9: On every hit exactly one outcome bit is set. `acc_class` is nonzero only for the two trap outcomes. `acc_offset` is nonzero only for the redirect outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access presented this cycle |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| cur_el | input | 2 | Exception level of the access (0..3) |
| el2_on | input | 1 | Hypervisor level enabled in the current security state |
| nest_en | input | 1 | Nested virtualization: trap-to-hypervisor control |
| nest_mem | input | 1 | Nested virtualization: memory-redirect control |
| sre_hyp | input | 1 | System-register interface enabled at level 2 |
| sre_mon | input | 1 | System-register interface enabled at level 3 |
| acc_hit | output | 1 | Registered: the previous access matched the encoding |
| acc_outcome | output | 5 | One-hot outcome: bit0 undefined, bit1 trap L2, bit2 trap L3, bit3 redirect, bit4 direct |
| acc_class | output | 6 | Syndrome class for a trap, else 0 |
| acc_offset | output | 12 | Memory slot offset for a redirect, else 0 |

## Verification
The bench drives all 128 combinations of level and control bits, so it covers the precedence cases. A decoder that checked the redirect after the trap would send the nest_en=nest_mem=1 case at level 1 to a trap. A decoder that ignored `el2_on` would redirect or trap when it should report undefined. Checking the enable of the wrong level at level 2 or 3 would flip trap and direct when only the other enable changes. One-field-off encodings and a valid-low cycle catch a partial encoding compare, which would report hits for neighbouring registers.

// File: rtl/sysreg_trap_pkg.sv
package sysreg_trap_pkg;

  typedef enum logic [1:0] {
    LVL_USER   = 2'd0,
    LVL_KERNEL = 2'd1,
    LVL_HYP    = 2'd2,
    LVL_MON    = 2'd3
  } lvl_e;

  localparam int OC_W        = 5;
  localparam int OC_UNDEF    = 0;
  localparam int OC_TRAP_HYP = 1;
  localparam int OC_TRAP_MON = 2;
  localparam int OC_REDIR    = 3;
  localparam int OC_DIRECT   = 4;

  typedef struct packed {
    logic [1:0] op0;
    logic [2:0] op1;
    logic [3:0] crn;
    logic [3:0] crm;
    logic [2:0] op2;
  } sysreg_enc_t;

  localparam int ENC_W = $bits(sysreg_enc_t);

  typedef struct packed {
    logic el2_on;
    logic nest_en;
    logic nest_mem;
    logic sre_hyp;
    logic sre_mon;
  } acc_ctl_t;

endpackage

// File: rtl/sysreg_enc_match.sv
module sysreg_enc_match
  import sysreg_trap_pkg::*;
#(
  parameter sysreg_enc_t TARGET = '0
) (
  input  logic        valid,
  input  sysreg_enc_t enc,
  output logic        hit
);
  logic [ENC_W-1:0] bit_eq;

  // Compare each bit of the incoming encoding with the target.
  for (genvar b = 0; b < ENC_W; b++) begin : g_bit
    assign bit_eq[b] = ~(enc[b] ^ TARGET[b]);
  end

  assign hit = valid & (&bit_eq);
endmodule

// File: rtl/sysreg_outcome_resolve.sv
module sysreg_outcome_resolve
  import sysreg_trap_pkg::*;
(
  input  lvl_e            lvl,
  input  acc_ctl_t        ctl,
  output logic [OC_W-1:0] oc
);
  logic kernel_nested;

  assign kernel_nested = ctl.el2_on & ctl.nest_en;

  always_comb begin
    oc = '0;
    unique case (lvl)
      LVL_USER:   oc[OC_UNDEF] = 1'b1;                      // R3
      LVL_KERNEL: begin
        if (kernel_nested && ctl.nest_mem) oc[OC_REDIR]    = 1'b1; // R4
        else if (kernel_nested)            oc[OC_TRAP_HYP] = 1'b1; // R5
        else                               oc[OC_UNDEF]    = 1'b1; // R6
      end
      LVL_HYP:    begin
        if (!ctl.sre_hyp) oc[OC_TRAP_HYP] = 1'b1;           // R7
        else              oc[OC_DIRECT]   = 1'b1;
      end
      default:    begin
        if (!ctl.sre_mon) oc[OC_TRAP_MON] = 1'b1;           // R8
        else              oc[OC_DIRECT]   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/sysreg_result_reg.sv
module sysreg_result_reg
  import sysreg_trap_pkg::*;
#(
  parameter int               SYN_W      = 6,
  parameter int               OFF_W      = 12,
  parameter logic [SYN_W-1:0] TRAP_CLASS = SYN_W'(6'h18),
  parameter logic [OFF_W-1:0] REDIR_OFF  = OFF_W'(12'h4C0)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic [OC_W-1:0]  oc,
  output logic             hit_q,
  output logic [OC_W-1:0]  oc_q,
  output logic [SYN_W-1:0] cls_q,
  output logic [OFF_W-1:0] off_q
);
  logic is_trap;
  logic is_redir;

  assign is_trap  = oc[OC_TRAP_HYP] | oc[OC_TRAP_MON];
  assign is_redir = oc[OC_REDIR];

  always_ff @(posedge clk) begin
    if (rst) begin                       // R1
      hit_q <= 1'b0;
      oc_q  <= '0;
      cls_q <= '0;
      off_q <= '0;
    end else begin
      hit_q <= hit;
      oc_q  <= hit ? oc : '0;            // R2
      cls_q <= (hit && is_trap)  ? TRAP_CLASS : '0;
      off_q <= (hit && is_redir) ? REDIR_OFF  : '0;
    end
  end
endmodule

// File: rtl/sysreg_trap_decoder.sv
module sysreg_trap_decoder
  import sysreg_trap_pkg::*;
#(
  parameter int               SYN_W      = 6,
  parameter int               OFF_W      = 12,
  parameter logic [SYN_W-1:0] TRAP_CLASS = SYN_W'(6'h18),
  parameter logic [OFF_W-1:0] REDIR_OFF  = OFF_W'(12'h4C0),
  parameter logic [1:0]       T_OP0      = 2'b11,
  parameter logic [2:0]       T_OP1      = 3'b100,
  parameter logic [3:0]       T_CRN      = 4'b1100,
  parameter logic [3:0]       T_CRM      = 4'b1011,
  parameter logic [2:0]       T_OP2      = 3'b000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_op0,
  input  logic [2:0]       req_op1,
  input  logic [3:0]       req_crn,
  input  logic [3:0]       req_crm,
  input  logic [2:0]       req_op2,
  input  logic [1:0]       cur_el,
  input  logic             el2_on,
  input  logic             nest_en,
  input  logic             nest_mem,
  input  logic             sre_hyp,
  input  logic             sre_mon,
  output logic             acc_hit,
  output logic [4:0]       acc_outcome,
  output logic [SYN_W-1:0] acc_class,
  output logic [OFF_W-1:0] acc_offset
);
  localparam sysreg_enc_t TARGET = '{op0: T_OP0, op1: T_OP1, crn: T_CRN,
                                     crm: T_CRM, op2: T_OP2};

  sysreg_enc_t     enc;
  acc_ctl_t        ctl;
  logic            hit;
  logic [OC_W-1:0] oc;

  assign enc = '{op0: req_op0, op1: req_op1, crn: req_crn,
                 crm: req_crm, op2: req_op2};
  assign ctl = '{el2_on: el2_on, nest_en: nest_en, nest_mem: nest_mem,
                 sre_hyp: sre_hyp, sre_mon: sre_mon};

  sysreg_enc_match #(.TARGET(TARGET)) u_match (
    .valid (req_valid),
    .enc   (enc),
    .hit   (hit)
  );

  sysreg_outcome_resolve u_resolve (
    .lvl (lvl_e'(cur_el)),
    .ctl (ctl),
    .oc  (oc)
  );

  sysreg_result_reg #(
    .SYN_W(SYN_W), .OFF_W(OFF_W), .TRAP_CLASS(TRAP_CLASS), .REDIR_OFF(REDIR_OFF)
  ) u_reg (
    .clk   (clk),
    .rst   (rst),
    .hit   (hit),
    .oc    (oc),
    .hit_q (acc_hit),
    .oc_q  (acc_outcome),
    .cls_q (acc_class),
    .off_q (acc_offset)
  );
endmodule

// File: rtl/sysreg_trap_decoder_chk.sv
module sysreg_trap_decoder_chk #(
  parameter int               SYN_W      = 6,
  parameter int               OFF_W      = 12,
  parameter logic [SYN_W-1:0] TRAP_CLASS = SYN_W'(6'h18),
  parameter logic [OFF_W-1:0] REDIR_OFF  = OFF_W'(12'h4C0),
  parameter logic [1:0]       T_OP0      = 2'b11,
  parameter logic [2:0]       T_OP1      = 3'b100,
  parameter logic [3:0]       T_CRN      = 4'b1100,
  parameter logic [3:0]       T_CRM      = 4'b1011,
  parameter logic [2:0]       T_OP2      = 3'b000
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [1:0]       req_op0,
  input logic [2:0]       req_op1,
  input logic [3:0]       req_crn,
  input logic [3:0]       req_crm,
  input logic [2:0]       req_op2,
  input logic [1:0]       cur_el,
  input logic             el2_on,
  input logic             nest_en,
  input logic             nest_mem,
  input logic             sre_hyp,
  input logic             sre_mon,
  input logic             acc_hit,
  input logic [4:0]       acc_outcome,
  input logic [SYN_W-1:0] acc_class,
  input logic [OFF_W-1:0] acc_offset
);
  logic enc_ok;
  assign enc_ok = req_valid && req_op0 == T_OP0 && req_op1 == T_OP1 &&
                  req_crn == T_CRN && req_crm == T_CRM && req_op2 == T_OP2;

  a_r2_hit_follows_match: assert property (@(posedge clk) disable iff (rst)
    enc_ok |=> acc_hit);

  a_r2_quiet_on_miss: assert property (@(posedge clk) disable iff (rst)
    !enc_ok |=> (!acc_hit && acc_outcome == 5'd0 && acc_class == '0 && acc_offset == '0));

  a_r3_user_undef: assert property (@(posedge clk) disable iff (rst)
    (enc_ok && cur_el == 2'd0) |=> acc_outcome == 5'b00001);

  a_r4_redirect: assert property (@(posedge clk) disable iff (rst)
    (enc_ok && cur_el == 2'd1 && el2_on && nest_en && nest_mem)
      |=> (acc_outcome == 5'b01000 && acc_offset == REDIR_OFF));

  a_r5_kernel_trap: assert property (@(posedge clk) disable iff (rst)
    (enc_ok && cur_el == 2'd1 && el2_on && nest_en && !nest_mem)
      |=> (acc_outcome == 5'b00010 && acc_class == TRAP_CLASS));

  a_r6_kernel_undef: assert property (@(posedge clk) disable iff (rst)
    (enc_ok && cur_el == 2'd1 && !(el2_on && nest_en)) |=> acc_outcome == 5'b00001);

  a_r7_hyp_level: assert property (@(posedge clk) disable iff (rst)
    (enc_ok && cur_el == 2'd2)
      |=> (acc_outcome == ($past(sre_hyp) ? 5'b10000 : 5'b00010)));

  a_r8_mon_level: assert property (@(posedge clk) disable iff (rst)
    (enc_ok && cur_el == 2'd3)
      |=> (acc_outcome == ($past(sre_mon) ? 5'b10000 : 5'b00100)));

  a_r9_one_hot: assert property (@(posedge clk) disable iff (rst)
    acc_hit |-> $countones(acc_outcome) == 1);

  a_r9_class_only_trap: assert property (@(posedge clk) disable iff (rst)
    (acc_class != '0) |-> (acc_outcome[1] || acc_outcome[2]));

  a_r9_offset_only_redir: assert property (@(posedge clk) disable iff (rst)
    (acc_offset != '0) |-> acc_outcome[3]);
endmodule

bind sysreg_trap_decoder sysreg_trap_decoder_chk #(
  .SYN_W(SYN_W), .OFF_W(OFF_W), .TRAP_CLASS(TRAP_CLASS), .REDIR_OFF(REDIR_OFF),
  .T_OP0(T_OP0), .T_OP1(T_OP1), .T_CRN(T_CRN), .T_CRM(T_CRM), .T_OP2(T_OP2)
) u_chk (.*);

// File: tb/sysreg_trap_decoder_tb.sv
module sysreg_trap_decoder_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [1:0]  req_op0;
  logic [2:0]  req_op1;
  logic [3:0]  req_crn, req_crm;
  logic [2:0]  req_op2;
  logic [1:0]  cur_el;
  logic        el2_on, nest_en, nest_mem, sre_hyp, sre_mon;
  logic        acc_hit;
  logic [4:0]  acc_outcome;
  logic [5:0]  acc_class;
  logic [11:0] acc_offset;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // expected values of the registered outputs after the next edge
  bit          e_hit;
  logic [4:0]  e_oc;
  logic [5:0]  e_cls;
  logic [11:0] e_off;
  string       e_tag;

  always #2 clk = ~clk;

  sysreg_trap_decoder u_dut (.*);

  function automatic void model(output string tag);
    bit ok;
    ok = req_valid && req_op0 == 2'b11 && req_op1 == 3'b100 && req_crn == 4'b1100 &&
         req_crm == 4'b1011 && req_op2 == 3'b000;
    e_hit = 0; e_oc = 0; e_cls = 0; e_off = 0;
    if (rst) begin tag = "R1"; return; end
    if (!ok) begin tag = "R2"; return; end
    e_hit = 1;
    case (cur_el)
      2'd0: begin e_oc = 5'b00001; tag = "R3/R9"; end
      2'd1: begin
        if (el2_on && nest_en && nest_mem) begin
          e_oc = 5'b01000; e_off = 12'h4C0; tag = "R4/R9";
        end else if (el2_on && nest_en) begin
          e_oc = 5'b00010; e_cls = 6'h18; tag = "R5/R9";
        end else begin
          e_oc = 5'b00001; tag = "R6/R9";
        end
      end
      2'd2: begin
        if (sre_hyp) e_oc = 5'b10000;
        else begin e_oc = 5'b00010; e_cls = 6'h18; end
        tag = "R7/R9";
      end
      default: begin
        if (sre_mon) e_oc = 5'b10000;
        else begin e_oc = 5'b00100; e_cls = 6'h18; end
        tag = "R8/R9";
      end
    endcase
  endfunction

  task automatic compare();
    total++;
    if (acc_hit !== e_hit || acc_outcome !== e_oc || acc_class !== e_cls ||
        acc_offset !== e_off) begin
      bad++;
      $display("FAIL %s: got hit=%0b oc=%b cls=%h off=%h, want hit=%0b oc=%b cls=%h off=%h",
               e_tag, acc_hit, acc_outcome, acc_class, acc_offset,
               e_hit, e_oc, e_cls, e_off);
    end
  endtask

  // One cycle: check outputs for the previous stimulus, then apply the next.
  task automatic step(input bit r, input bit v, input logic [15:0] enc,
                      input logic [1:0] el, input logic [4:0] c);
    @(negedge clk);
    if (e_tag != "") compare();
    rst = r; req_valid = v;
    {req_op0, req_op1, req_crn, req_crm, req_op2} = enc;
    cur_el = el;
    {el2_on, nest_en, nest_mem, sre_hyp, sre_mon} = c;
    model(e_tag);
  endtask

  localparam logic [15:0] ENC = {2'b11, 3'b100, 4'b1100, 4'b1011, 3'b000};

  initial begin
    e_tag = "";
    rst = 1; req_valid = 0; {req_op0, req_op1, req_crn, req_crm, req_op2} = '0;
    cur_el = 0; {el2_on, nest_en, nest_mem, sre_hyp, sre_mon} = '0;
    // R1: reset holds outputs at zero even with a matching access present
    step(1, 1, ENC, 2'd2, 5'b11111);
    step(1, 1, ENC, 2'd1, 5'b11100);
    step(0, 0, ENC, 2'd2, 5'b11111);            // R2: valid low
    // R3..R9: every level and control combination
    for (int el = 0; el < 4; el++)
      for (int c = 0; c < 32; c++)
        step(0, 1, ENC, el[1:0], c[4:0]);
    // R2: single-field and single-bit mismatches
    for (int b = 0; b < 16; b++)
      step(0, 1, ENC ^ (16'h1 << b), 2'd2, 5'b11111);
    step(0, 1, {2'b10, ENC[13:0]}, 2'd3, 5'b00000);
    // back-to-back alternation: hit, miss, hit
    step(0, 1, ENC, 2'd1, 5'b11100);
    step(0, 1, ENC ^ 16'h0008, 2'd1, 5'b11100);
    step(0, 1, ENC, 2'd3, 5'b00000);
    // R1: reset in mid-stream
    step(1, 1, ENC, 2'd3, 5'b00000);
    step(0, 1, ENC, 2'd0, 5'b11111);
    step(0, 0, '0, 2'd0, 5'b00000);
    @(negedge clk);
    compare();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got no end, want end of stimulus");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule